// File: doc/BRIEF.md
# Motor PWM Time Base Generator

This block is the timing heart of a motor-control PWM channel. A 15-bit counter advances once per prescaler tick. The prescaler divides the clock-enable stream by 1, 4, 16 or 64. The counter either counts up and wraps, or counts up and down in a triangle. It drives one edge-aligned PWM output by comparing the counter against a duty value. It also raises a one-cycle interrupt pulse that a 4-bit postscaler can thin out.

The active period and duty values come from buffer registers. Software writes the buffers at any time. The active values only change at a safe point in the count, so a running waveform never glitches. While the time base is stopped, the buffers pass straight through.

Four modes are available: free-running, single-shot, continuous up/down, and up/down with an interrupt at both ends of the triangle. In the last mode the controller can refresh its duty twice per PWM cycle. Software reaches everything through a small word-addressed write port.

Top module: `mc_pwm_timebase`

## Requirements
- R1: The write port decodes four addresses: 0 control, 1 period buffer, 2 counter, 3 duty buffer. In the control word, bit 0 is run, bits [2:1] are the mode (00 free-running, 01 single-shot, 10 up/down, 11 up/down with dual interrupt), bits [4:3] are the prescale select and bits [8:5] are the postscale value N. After reset, count, pwm_out, irq and running are all 0.
- R2: The counter advances only on a prescaler tick. Ticks come once every 1, 4, 16 or 64 cycles in which clk_en and run are both high, for prescale select 0, 1, 2 or 3. While clk_en is low the count holds.
- R3: In free-running mode with period P, the count goes 0, 1, …, P and returns to 0 on the next tick. One cycle therefore lasts P+1 ticks.
- R4: Single-shot mode counts like R3. On the tick that wraps to 0 it clears run, pulses irq once and then holds the count at 0.
- R5: In up/down modes the count rises from 0 to P, then falls back to 0. The tick at P turns it down and the tick at 0 turns it up, giving a cycle of 2P ticks.
- R6: In modes 00, 01 and 10, a period match is the tick that finds the counter at P while counting up (or at or above P in the wrapping modes). irq pulses high for one cycle after every (N+1)-th period match.
- R7: In mode 11, irq pulses after every period match and after every tick taken from count 0, and N has no effect. With P=1 it pulses after every tick.
- R8: A write to the control or counter address clears both the prescaler and the postscaler. A control write leaves the count unchanged. A counter write loads the written value, which takes priority over a tick in the same cycle.
- R9: While running, the active period loads from its buffer on the wrap in modes 00 and 01, and on the tick taken from count 0 in modes 10 and 11. While stopped, it follows the buffer one cycle after a write.
- R10: The active duty loads from its buffer at exactly the same instants as the period.
- R11: pwm_out is high while running and the count is below the active duty. A duty of 0 keeps it low all the time, a duty above P keeps it high all the time, and it is low while stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clk_en | input | 1 | Count-clock enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (R1) |
| wr_data | input | 15 | Write data |
| pwm_out | output | 1 | Edge-aligned PWM output |
| irq | output | 1 | One-cycle interrupt pulse |
| count | output | 15 | Current counter value |
| running | output | 1 | Run bit, cleared by hardware in single-shot mode |

## Verification
The bench sweeps every prescale ratio against several periods, postscale values and duties in three modes. It predicts the count, the PWM level and the interrupt for every cycle by arithmetic. A design with the prescaler phase off by one, or one that forgets to reload it after a tick, shows up as a count that drifts. The up/down turn points are checked tick by tick: a design that lingers a tick at 0 or at P would stretch the triangle, and one that drops the zero-end interrupt in dual mode would miss pulses, most visibly at a period of 1, where every tick must interrupt. Directed cases rewrite the period and duty buffers mid-cycle and expect the old values to hold until the wrap, or until the bottom of the triangle; a design that loads them at once cuts the cycle short. Further cases check that a control rewrite neither resets the count nor lets a stale postscaler count fire an early interrupt, and that single-shot halts with one pulse and never restarts.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

  typedef enum logic [1:0] {
    MD_FREE = 2'b00,
    MD_ONCE = 2'b01,
    MD_UPDN = 2'b10,
    MD_DUAL = 2'b11
  } tb_mode_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_PER  = 2'd1;
  localparam logic [1:0] ADR_CNT  = 2'd2;
  localparam logic [1:0] ADR_DUTY = 2'd3;

endpackage

// File: rtl/mcpwm_prescale.sv
module mcpwm_prescale #(
  parameter int SEL_W     = 2,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = STEP_LOG2 * ((1 << SEL_W) - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last = ~({DIV_W{1'b1}} << (STEP_LOG2 * sel));
    tick = adv && (cnt_q == last);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (adv)  cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: with no enabled clock and no clear, the divider phase holds
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !clr |=> $stable(cnt_q));

endmodule

// File: rtl/mcpwm_postscale.sv
module mcpwm_postscale #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt,
  input  logic            clr,
  input  logic [PS_W-1:0] ratio,
  output logic            fire
);
  logic [PS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    fire  = evt && (cnt_q == ratio);
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (evt) cnt_d = fire ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6/R8: ratio only changes with a control write, which clears the count
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio);

endmodule

// File: rtl/mcpwm_counter.sv
module mcpwm_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             updn,
  input  logic             run,
  input  logic             cnt_wr,
  input  logic             per_wr,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] duty_act,
  output logic             match_evt,
  output logic             zero_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, duty_q, duty_d;
  logic [CNT_W-1:0] pbuf_q, pbuf_d, dbuf_q, dbuf_d;
  logic             up_q, up_d, at_top, load_evt;

  always_comb begin
    at_top    = cnt_q >= per_q;
    match_evt = 1'b0;
    zero_evt  = 1'b0;
    cnt_d     = cnt_q;
    up_d      = up_q;
    if (tick) begin
      if (!updn) begin
        if (at_top) begin
          cnt_d     = '0;
          match_evt = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        zero_evt = 1'b1;
        up_d     = 1'b1;
        cnt_d    = (per_q == '0) ? '0 : CNT_W'(1);
      end else if (up_q && at_top) begin
        match_evt = 1'b1;
        up_d      = 1'b0;
        cnt_d     = cnt_q - 1'b1;
      end else if (up_q) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (cnt_wr) begin
      cnt_d = wr_val;
      up_d  = 1'b1;
    end
    load_evt = !run || (updn ? zero_evt : match_evt);
    pbuf_d   = per_wr  ? wr_val : pbuf_q;
    dbuf_d   = duty_wr ? wr_val : dbuf_q;
    per_d    = load_evt ? pbuf_q : per_q;
    duty_d   = load_evt ? dbuf_q : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      per_q  <= '0;
      duty_q <= '0;
      pbuf_q <= '0;
      dbuf_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      pbuf_q <= pbuf_d;
      dbuf_q <= dbuf_d;
    end
  end

  assign cnt      = cnt_q;
  assign per_act  = per_q;
  assign duty_act = duty_q;

  // R3: a tick at or past the period in a wrapping mode lands on zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !updn && (cnt_q >= per_q) && !cnt_wr |=> cnt_q == '0);

  // R5: the bottom of the triangle turns straight back up
  a_r5_turn_up: assert property (@(posedge clk) disable iff (!rst_n)
    tick && updn && (cnt_q == '0) && !cnt_wr |=> cnt_q <= CNT_W'(1));

  // R9: the active period moves only at a load instant
  a_r9_period_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_q) |-> $past(load_evt));

  // R10: the active duty moves only at a load instant
  a_r10_duty_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> $past(load_evt));

endmodule

// File: rtl/mc_pwm_timebase.sv
module mc_pwm_timebase
  import mcpwm_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int SEL_W = 2,
  parameter int PS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             irq,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  localparam int SEL_LO  = 3;
  localparam int POST_LO = SEL_LO + SEL_W;

  tb_mode_e         mode_q, mode_d;
  logic             run_q, run_d, irq_q, irq_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [PS_W-1:0]  post_q, post_d;
  logic             wr_ctrl, wr_per, wr_cnt, wr_duty, pre_clr;
  logic             tick, match_evt, zero_evt, post_fire, dual;
  logic [CNT_W-1:0] cnt, per_act, duty_act;

  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
  assign wr_per  = wr_en && (wr_addr == ADR_PER);
  assign wr_cnt  = wr_en && (wr_addr == ADR_CNT);
  assign wr_duty = wr_en && (wr_addr == ADR_DUTY);
  assign pre_clr = wr_ctrl || wr_cnt;
  assign dual    = (mode_q == MD_DUAL);

  mcpwm_prescale #(.SEL_W(SEL_W), .STEP_LOG2(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .adv(clk_en && run_q), .clr(pre_clr),
    .sel(sel_q), .tick(tick));

  mcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .updn(mode_q[1]), .run(run_q),
    .cnt_wr(wr_cnt), .per_wr(wr_per), .duty_wr(wr_duty), .wr_val(wr_data),
    .cnt(cnt), .per_act(per_act), .duty_act(duty_act),
    .match_evt(match_evt), .zero_evt(zero_evt));

  mcpwm_postscale #(.PS_W(PS_W)) u_post (
    .clk(clk), .rst_n(rst_n), .evt(match_evt && !dual), .clr(pre_clr),
    .ratio(post_q), .fire(post_fire));

  always_comb begin
    mode_d = mode_q;
    sel_d  = sel_q;
    post_d = post_q;
    run_d  = run_q;
    if (wr_ctrl) begin
      run_d  = wr_data[0];
      mode_d = tb_mode_e'(wr_data[2:1]);
      sel_d  = wr_data[SEL_LO +: SEL_W];
      post_d = wr_data[POST_LO +: PS_W];
    end else if (mode_q == MD_ONCE && match_evt) begin
      run_d = 1'b0;
    end
    irq_d = dual ? (match_evt || zero_evt) : post_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_FREE;
      sel_q  <= '0;
      post_q <= '0;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
      post_q <= post_d;
      run_q  <= run_d;
      irq_q  <= irq_d;
    end
  end

  assign pwm_out = run_q && (cnt < duty_act);
  assign irq     = irq_q;
  assign count   = cnt;
  assign running = run_q;

  // R4: a single-shot wrap stops the time base
  a_r4_once_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONCE) && match_evt && !wr_ctrl |=> !run_q);

  // R6: every interrupt pulse follows a prescaler tick
  a_r6_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));

  // R7: dual mode interrupts at the bottom of the triangle
  a_r7_dual_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    dual && zero_evt |=> irq);

  // R11: a zero duty never lets the output go active
  a_r11_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm_out);

endmodule

// File: tb/mc_pwm_timebase_test.sv
module mc_pwm_timebase_test;
  localparam int W = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clk_en = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         pwm_out, irq, running;
  logic [W-1:0] count;

  int vec = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_pwm_timebase uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq),
    .count(count), .running(running));

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = a[1:0];
    wr_data = d[W-1:0];
    step();
    wr_en   = 1'b0;
  endtask

  function automatic int ctl(int run, int md, int sel, int post);
    return run | (md << 1) | (sel << 3) | (post << 5);
  endfunction

  task automatic setup(input int md, input int sel, input int post,
                       input int per, input int duty);
    wr(0, 0);
    wr(2, 0);
    wr(1, per);
    wr(3, duty);
    step();
    wr(0, ctl(1, md, sel, post));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset pwm", int'(pwm_out), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset running", int'(running), 0);

    // Sweep: modes 00/10/11, all prescale ratios, several periods
    for (int m = 0; m < 3; m++)
      for (int sel = 0; sel < 4; sel++)
        for (int pi = 0; pi < 3; pi++)
          for (int po = 0; po < 2; po++) begin
            int md, P, post, r, duty, N;
            string ctag, itag;
            md   = (m == 0) ? 0 : ((m == 1) ? 2 : 3);
            P    = (pi == 0) ? 1 : ((pi == 1) ? 2 : 5);
            post = po * 3;
            r    = 1 << (2 * sel);
            duty = (sel % 3 == 0) ? 0 : ((sel % 3 == 1) ? 2 : P + 2);
            N    = r * 2 * (2 * P + 2) * (post + 1);
            if (md != 0)      ctag = "R5 count";
            else if (sel > 0) ctag = "R2 count";
            else              ctag = "R3 count";
            itag = (md == 3) ? "R7 irq" : "R6 irq";
            setup(md, sel, post, P, duty);
            for (int n = 1; n <= N; n++) begin
              int T, ec, k, u, ph;
              bit tk, mt, zr, ei;
              step();
              T  = n / r;
              tk = (n % r == 0) && (T > 0);
              zr = 1'b0;
              if (md == 0) begin
                ec = T % (P + 1);
                mt = tk && (T % (P + 1) == 0);
                k  = T / (P + 1);
              end else begin
                ph = T % (2 * P);
                ec = (ph <= P) ? ph : 2 * P - ph;
                u  = T - 1;
                mt = tk && (u % (2 * P) == P);
                zr = tk && (u % (2 * P) == 0);
                k  = (u - P) / (2 * P) + 1;
              end
              ei = (md == 3) ? (mt || zr) : (mt && (k % (post + 1) == 0));
              chk(ctag, int'(count), ec);
              chk("R11 pwm", int'(pwm_out), (ec < duty) ? 1 : 0);
              chk(itag, int'(irq), ei ? 1 : 0);
            end
          end

    // R4 single-shot
    setup(1, 0, 0, 3, 2);
    for (int n = 1; n <= 3; n++) begin
      step();
      chk("R4 count", int'(count), n);
      chk("R4 running", int'(running), 1);
    end
    step();
    chk("R4 wrap count", int'(count), 0);
    chk("R4 wrap running", int'(running), 0);
    chk("R4 wrap irq", int'(irq), 1);
    for (int n = 0; n < 4; n++) begin
      step();
      chk("R4 halted count", int'(count), 0);
      chk("R4 halted irq", int'(irq), 0);
      chk("R11 stopped pwm", int'(pwm_out), 0);
    end

    // R2 clock enable hold
    setup(0, 0, 0, 9, 0);
    repeat (3) step();
    chk("R2 count", int'(count), 3);
    clk_en = 1'b0;
    for (int n = 0; n < 5; n++) begin
      step();
      chk("R2 clk_en low hold", int'(count), 3);
    end
    clk_en = 1'b1;
    step();
    chk("R2 clk_en resume", int'(count), 4);

    // R8 control rewrite keeps count, restarts prescaler at 1:4
    wr(0, ctl(1, 0, 1, 0));
    chk("R8 ctrl write count", int'(count), 5);
    for (int n = 0; n < 3; n++) begin
      step();
      chk("R8 prescaler restart", int'(count), 5);
    end
    step();
    chk("R2 1:4 tick", int'(count), 6);
    wr(2, 7);
    chk("R8 counter write", int'(count), 7);
    for (int n = 0; n < 3; n++) begin
      step();
      chk("R8 counter write hold", int'(count), 7);
    end
    step();
    chk("R8 after counter write", int'(count), 8);

    // R8 postscaler cleared by control write
    setup(0, 0, 1, 1, 0);
    step();
    step();
    chk("R6 first match no irq", int'(irq), 0);
    wr(0, ctl(1, 0, 0, 1));
    chk("R8 count", int'(count), 1);
    step();
    chk("R8 postscaler cleared", int'(irq), 0);
    step();
    step();
    chk("R8 postscaler second match", int'(irq), 1);

    // R9/R10 buffered period and duty, free-running
    setup(0, 0, 0, 5, 3);
    step();
    step();
    wr(1, 3);
    wr(3, 6);
    chk("R9 count", int'(count), 4);
    chk("R10 pwm", int'(pwm_out), 0);
    begin
      int ecnt[7] = '{5, 0, 1, 2, 3, 0, 1};
      int epwm[7] = '{0, 1, 1, 1, 1, 1, 1};
      for (int n = 0; n < 7; n++) begin
        step();
        chk("R9 buffered period", int'(count), ecnt[n]);
        chk("R10 buffered duty", int'(pwm_out), epwm[n]);
      end
    end

    // R9 up/down period load at zero
    setup(2, 0, 0, 4, 0);
    step();
    step();
    wr(1, 2);
    begin
      int eud[10] = '{4, 3, 2, 1, 0, 1, 2, 1, 0, 1};
      for (int n = 0; n < 10; n++) begin
        step();
        chk("R9 up/down load", int'(count), eud[n]);
      end
    end

    // R11 output low once stopped
    setup(0, 0, 0, 5, 3);
    step();
    chk("R11 running pwm", int'(pwm_out), 1);
    wr(0, 0);
    chk("R11 stopped pwm", int'(pwm_out), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule